// File: doc/BRIEF.md
# Registered Four-Bit Function-Select ALU

This block is a small arithmetic/logic unit in the manner of the classic sixteen-by-two function-select parts. Two operands, a four-bit select code and a mode bit choose one of thirty-two operations: in logic mode a bitwise function of the operands, and in arithmetic mode a sum of two select-dependent terms built from the operands. A carry-in joins that sum. The carry-in and carry-out are active low. Alongside the result the unit reports an all-ones flag, which doubles as an equality test in subtract mode. It also reports active-low group propagate and group generate terms taken from its carry look-ahead.

Every input is captured in a flip-flop, and every output is driven from a flip-flop. The unit therefore drops straight into a pipelined datapath with no timing path running from its pins into or out of its logic. Internally each bit forms an OR-style term X and an AND-style term Y from the operands and the select code. A look-ahead network forms every carry from those terms in two levels of logic. A per-bit stage then picks the logic or the arithmetic output.

Top module: `registered_alu181`

## Requirements
- R1: While `rst` is high at a rising edge, all input and output registers clear to zero, so every output reads 0 after that edge.
- R2: Inputs present before rising edge n appear at the outputs after edge n+1. After edge n alone, the outputs still show the previous operation.
- R3: With `mode_i`=1 (logic), `f_o` is bitwise, by `sel_i`: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 all zeros, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 all ones, 1101 A|~B, 1110 A|B, 1111 A.
- R4: With `mode_i`=0 (arithmetic), `f_o` is the low four bits of X+Y+c. X and Y by `sel_i` are: 0000 A,0; 0001 A|B,0; 0010 A|~B,0; 0011 1111,0; 0100 A,A&~B; 0101 A|B,A&~B; 0110 A|~B,A&~B; 0111 1111,A&~B; 1000 A,A&B; 1001 A|B,A&B; 1010 A|~B,A&B; 1011 1111,A&B; 1100 A,A; 1101 A|B,A; 1110 A|~B,A; 1111 1111,A.
- R5: The carry-in is active low: c = 1 when `cin_n_i`=0 and c = 0 when `cin_n_i`=1. In logic mode the carry-in has no effect, and `cout_n_o` is 1.
- R6: In arithmetic mode `cout_n_o` is the inverse of bit 4 of X+Y+c.
- R7: `eq_o` is 1 exactly when all four bits of `f_o` are 1. With `sel_i`=0110, `mode_i`=0 and `cin_n_i`=1, this happens exactly when A equals B.
- R8: `g_n_o` is 0 exactly when X+Y carries out of bit 3 with no carry-in. `p_n_o` is 0 exactly when X is all ones. Both follow `sel_i` in either mode and ignore the carry-in.
- R9: For A=1010 and B=1001, logic mode gives: `sel_i`=0000 gives 0101, 0110 gives 0011, 1011 gives 1000, and 1110 gives 1011. Arithmetic mode with `cin_n_i`=1 gives: `sel_i`=0110 gives 0000, 1001 gives 0011, 1100 gives 0100, and 1111 gives 1001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| sel_i | input | 4 | Function select code |
| mode_i | input | 1 | 1 selects logic, 0 selects arithmetic |
| cin_n_i | input | 1 | Active-low carry-in |
| f_o | output | 4 | Registered result |
| cout_n_o | output | 1 | Registered active-low carry-out |
| eq_o | output | 1 | Registered all-ones flag |
| p_n_o | output | 1 | Registered active-low group propagate |
| g_n_o | output | 1 | Registered active-low group generate |

## Verification
On every cycle the assertions check several properties. After reset the outputs are cleared. The all-ones flag agrees with the result. Logic mode never reports a carry. An active group generate, or an active propagate together with an active carry-in, always produces an active carry-out in arithmetic mode. Outputs hold while the captured inputs hold. The exact value of each of the thirty-two functions, the two-edge latency and the worked operand examples are shown only by the bench. It sweeps every combination of operands, select code, mode and carry-in against arithmetic it computes itself.

// File: rtl/alu181_pkg.sv
package alu181_pkg;

   typedef enum logic {
      MODE_ARITH = 1'b0,
      MODE_LOGIC = 1'b1
   } alu_mode_e;

   typedef struct packed {
      logic cout_n;
      logic all_ones;
      logic grp_p_n;
      logic grp_g_n;
   } alu_flags_t;

endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [3:0]       sel,
   output logic [WIDTH-1:0] or_term,
   output logic [WIDTH-1:0] and_term
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign or_term[i]  = opa[i] | (sel[0] & opb[i]) | (sel[1] & ~opb[i]);
      assign and_term[i] = (sel[2] & opa[i] & ~opb[i]) | (sel[3] & opa[i] & opb[i]);
   end

endmodule

// File: rtl/alu_lookahead.sv
module alu_lookahead #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] prop,
   input  logic [WIDTH-1:0] gen,
   input  logic             c_in,
   output logic [WIDTH:0]   carry,
   output logic             grp_p_n,
   output logic             grp_g_n
);

   logic [WIDTH-1:0] gen_chain;

   always_comb begin : c_tree
      logic term;
      logic acc;
      carry[0]  = c_in;
      gen_chain = '0;
      for (int i = 0; i < WIDTH; i++) begin
         acc = 1'b0;
         for (int j = 0; j <= i; j++) begin
            term = gen[j];
            for (int k = j + 1; k <= i; k++) begin
               term = term & prop[k];
            end
            acc = acc | term;
         end
         gen_chain[i] = acc;
         term = c_in;
         for (int k = 0; k <= i; k++) begin
            term = term & prop[k];
         end
         carry[i+1] = acc | term;
      end
   end

   assign grp_g_n = ~gen_chain[WIDTH-1];
   assign grp_p_n = ~(&prop);

endmodule

// File: rtl/alu_result.sv
module alu_result
   import alu181_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  alu_mode_e        mode,
   input  logic [WIDTH-1:0] or_term,
   input  logic [WIDTH-1:0] and_term,
   input  logic [WIDTH-1:0] carry,
   output logic [WIDTH-1:0] res
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic logic_bit;
      logic sum_bit;
      assign logic_bit = ~or_term[i] | and_term[i];
      assign sum_bit   = or_term[i] ^ and_term[i] ^ carry[i];
      assign res[i]    = (mode == MODE_LOGIC) ? logic_bit : sum_bit;
   end

endmodule

// File: rtl/registered_alu181.sv
module registered_alu181
   import alu181_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter bit REG_OUTPUTS = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       sel_i,
   input  logic             mode_i,
   input  logic             cin_n_i,
   output logic [WIDTH-1:0] f_o,
   output logic             cout_n_o,
   output logic             eq_o,
   output logic             p_n_o,
   output logic             g_n_o
);

   localparam int CAP_W = 2 * WIDTH + 6;

   if (WIDTH < 2 || WIDTH > 16) begin : g_bad_width
      $error("registered_alu181: WIDTH must lie in 2..16");
   end

   // input capture stage
   logic [WIDTH-1:0] cap_a;
   logic [WIDTH-1:0] cap_b;
   logic [3:0]       cap_sel;
   alu_mode_e        cap_mode;
   logic             cap_cin_n;
   logic [CAP_W-1:0] cap_bus;

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_a     <= '0;
         cap_b     <= '0;
         cap_sel   <= '0;
         cap_mode  <= MODE_ARITH;
         cap_cin_n <= 1'b0;
      end else begin
         cap_a     <= a_i;
         cap_b     <= b_i;
         cap_sel   <= sel_i;
         cap_mode  <= alu_mode_e'(mode_i);
         cap_cin_n <= cin_n_i;
      end
   end

   assign cap_bus = {cap_a, cap_b, cap_sel, cap_mode, cap_cin_n};

   // combinational core
   logic [WIDTH-1:0] or_term;
   logic [WIDTH-1:0] and_term;
   logic [WIDTH:0]   carry;
   logic [WIDTH-1:0] res_c;
   logic             grp_p_n_c;
   logic             grp_g_n_c;
   alu_flags_t       flags_c;

   alu_bit_terms #(.WIDTH(WIDTH)) u_terms (
      .opa      (cap_a),
      .opb      (cap_b),
      .sel      (cap_sel),
      .or_term  (or_term),
      .and_term (and_term)
   );

   alu_lookahead #(.WIDTH(WIDTH)) u_cla (
      .prop    (or_term),
      .gen     (and_term),
      .c_in    (~cap_cin_n),
      .carry   (carry),
      .grp_p_n (grp_p_n_c),
      .grp_g_n (grp_g_n_c)
   );

   alu_result #(.WIDTH(WIDTH)) u_res (
      .mode     (cap_mode),
      .or_term  (or_term),
      .and_term (and_term),
      .carry    (carry[WIDTH-1:0]),
      .res      (res_c)
   );

   always_comb begin
      flags_c.cout_n   = (cap_mode == MODE_LOGIC) ? 1'b1 : ~carry[WIDTH];
      flags_c.all_ones = &res_c;
      flags_c.grp_p_n  = grp_p_n_c;
      flags_c.grp_g_n  = grp_g_n_c;
   end

   // output stage
   logic [WIDTH-1:0] f_q;
   alu_flags_t       flags_q;

   if (REG_OUTPUTS) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            f_q     <= '0;
            flags_q <= '0;
         end else begin
            f_q     <= res_c;
            flags_q <= flags_c;
         end
      end
   end else begin : g_out_comb
      assign f_q     = res_c;
      assign flags_q = flags_c;
   end

   assign f_o      = f_q;
   assign cout_n_o = flags_q.cout_n;
   assign eq_o     = flags_q.all_ones;
   assign p_n_o    = flags_q.grp_p_n;
   assign g_n_o    = flags_q.grp_g_n;

endmodule

// File: rtl/alu181_checker.sv
module alu181_checker #(
   parameter int WIDTH = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic [2*WIDTH+5:0]   cap_bus,
   input logic [WIDTH-1:0]     f_o,
   input logic                 cout_n_o,
   input logic                 eq_o,
   input logic                 p_n_o,
   input logic                 g_n_o
);

   // cap_bus layout: {a, b, sel, mode, cin_n}
   logic cap_mode;
   logic cap_cin_n;
   logic mode_d;
   logic cin_n_d;

   assign cap_mode  = cap_bus[1];
   assign cap_cin_n = cap_bus[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_d  <= 1'b0;
         cin_n_d <= 1'b0;
      end else begin
         mode_d  <= cap_mode;
         cin_n_d <= cap_cin_n;
      end
   end

   // R1: outputs cleared by reset
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (f_o == '0 && !cout_n_o && !eq_o && !p_n_o && !g_n_o));

   // R2: held captured inputs give held outputs
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && cap_bus == $past(cap_bus))
      |=> $stable({f_o, cout_n_o, eq_o, p_n_o, g_n_o}));

   // R5: logic mode never signals a carry
   p_logic_no_carry_r5: assert property (@(posedge clk) disable iff (rst)
      cap_mode |=> cout_n_o);

   // R7: flag follows the result
   p_all_ones_r7: assert property (@(posedge clk) disable iff (rst)
      eq_o == (&f_o));

   // R8: active generate, or active propagate with carry-in, forces carry-out
   p_group_carry_r8: assert property (@(posedge clk) disable iff (rst)
      (!mode_d && (!g_n_o || (!p_n_o && !cin_n_d))) |-> !cout_n_o);

endmodule

bind registered_alu181 alu181_checker #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cap_bus  (cap_bus),
   .f_o      (f_o),
   .cout_n_o (cout_n_o),
   .eq_o     (eq_o),
   .p_n_o    (p_n_o),
   .g_n_o    (g_n_o)
);

// File: tb/sim_registered_alu181.sv
module sim_registered_alu181;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] a_i = '0;
   logic [3:0] b_i = '0;
   logic [3:0] sel_i = '0;
   logic       mode_i = 1'b0;
   logic       cin_n_i = 1'b1;
   logic [3:0] f_o;
   logic       cout_n_o, eq_o, p_n_o, g_n_o;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   registered_alu181 u0 (
      .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .sel_i(sel_i),
      .mode_i(mode_i), .cin_n_i(cin_n_i), .f_o(f_o), .cout_n_o(cout_n_o),
      .eq_o(eq_o), .p_n_o(p_n_o), .g_n_o(g_n_o)
   );

   // expected {f, cout_n, eq, p_n, g_n}
   function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b,
                                        input logic [3:0] s, input logic m,
                                        input logic cn);
      logic [3:0] x, y, f;
      logic [4:0] sum, gsum;
      logic       co_n;
      case (s[1:0])
         2'b00: x = a;
         2'b01: x = a | b;
         2'b10: x = a | ~b;
         default: x = 4'hF;
      endcase
      case (s[3:2])
         2'b00: y = 4'h0;
         2'b01: y = a & ~b;
         2'b10: y = a & b;
         default: y = a;
      endcase
      sum  = {1'b0, x} + {1'b0, y} + {4'b0, ~cn};
      gsum = {1'b0, x} + {1'b0, y};
      if (m) begin
         case (s)
            4'h0: f = ~a;
            4'h1: f = ~(a | b);
            4'h2: f = ~a & b;
            4'h3: f = 4'h0;
            4'h4: f = ~(a & b);
            4'h5: f = ~b;
            4'h6: f = a ^ b;
            4'h7: f = a & ~b;
            4'h8: f = ~a | b;
            4'h9: f = ~(a ^ b);
            4'hA: f = b;
            4'hB: f = a & b;
            4'hC: f = 4'hF;
            4'hD: f = a | ~b;
            4'hE: f = a | b;
            default: f = a;
         endcase
         co_n = 1'b1;
      end else begin
         f    = sum[3:0];
         co_n = ~sum[4];
      end
      return {f, co_n, &f, ~(&x), ~gsum[4]};
   endfunction

   function automatic logic [7:0] outs();
      return {f_o, cout_n_o, eq_o, p_n_o, g_n_o};
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                        input logic m, input logic cn);
      a_i = a; b_i = b; sel_i = s; mode_i = m; cin_n_i = cn;
   endtask

   // drive at a falling edge, wait two rising edges, sample at the next falling edge
   task automatic apply(input string tag, input logic [3:0] a, input logic [3:0] b,
                        input logic [3:0] s, input logic m, input logic cn);
      @(negedge clk);
      drive(a, b, s, m, cn);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check(tag, outs(), model(a, b, s, m, cn));
   endtask

   task automatic apply_f(input string tag, input logic [3:0] s, input logic m,
                          input logic [3:0] exp_f);
      @(negedge clk);
      drive(4'b1010, 4'b1001, s, m, 1'b1);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check(tag, {f_o, 4'b0}, {exp_f, 4'b0});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin : stim
      // R1: reset clears outputs even with busy inputs
      drive(4'hF, 4'hF, 4'hF, 1'b0, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset", outs(), 8'h00);
      rst = 1'b0;

      // R9: worked examples
      apply_f("R9 not a", 4'b0000, 1'b1, 4'b0101);
      apply_f("R9 xor",   4'b0110, 1'b1, 4'b0011);
      apply_f("R9 and",   4'b1011, 1'b1, 4'b1000);
      apply_f("R9 or",    4'b1110, 1'b1, 4'b1011);
      apply_f("R9 a-b-1", 4'b0110, 1'b0, 4'b0000);
      apply_f("R9 a+b",   4'b1001, 1'b0, 4'b0011);
      apply_f("R9 a+a",   4'b1100, 1'b0, 4'b0100);
      apply_f("R9 a-1",   4'b1111, 1'b0, 4'b1001);

      // R2: latency of two edges from pins to outputs
      apply("R2 setup", 4'h3, 4'h5, 4'b1001, 1'b0, 1'b1);
      @(negedge clk);
      drive(4'hC, 4'h1, 4'b0110, 1'b1, 1'b1);
      @(posedge clk);
      @(negedge clk);
      check("R2 old value after one edge", outs(), model(4'h3, 4'h5, 4'b1001, 1'b0, 1'b1));
      @(posedge clk);
      @(negedge clk);
      check("R2 new value after two edges", outs(), model(4'hC, 4'h1, 4'b0110, 1'b1, 1'b1));

      // R5: carry-in ignored in logic mode, active low in arithmetic
      apply("R5 logic cin0", 4'h6, 4'h3, 4'b1110, 1'b1, 1'b0);
      apply("R5 arith cin0", 4'hF, 4'h0, 4'b0000, 1'b0, 1'b0);
      apply("R6 carry out", 4'hF, 4'h1, 4'b1001, 1'b0, 1'b1);
      // R7: equality via subtract
      apply("R7 equal", 4'h7, 4'h7, 4'b0110, 1'b0, 1'b1);
      apply("R7 unequal", 4'h7, 4'h6, 4'b0110, 1'b0, 1'b1);

      // R3 R4 R5 R6 R7 R8: exhaustive sweep of every input combination
      for (int v = 0; v < 16384; v++) begin
         logic [13:0] w;
         w = v[13:0];
         apply(w[13] ? "R3 R5 R7 R8 logic sweep" : "R4 R5 R6 R7 R8 arith sweep",
               w[7:4], w[3:0], w[11:8], w[13], w[12]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule